// File: doc/BRIEF.md
# Configurable GPIO Pin Mode Controller

This block drives the pad controls for a small bank of general-purpose pins. Each configurable pin takes a 2-bit mode from a configuration register. The mode selects one of four output styles: quasi-bidirectional, input-only, push-pull or open-drain. For every pin the block produces four separate driver enables: a strong pull-up, a weak pull-up, a very weak pull-up and a pull-down. The analog pad turns these enables into drive strength.

A state register holds one output latch bit per pin. A host write updates the latch only for pins that can drive. A host read returns the level each pin actually sits at, after a glitch-rejecting filter. Two more pins have no configuration bits and always behave as quasi-bidirectional.

In quasi-bidirectional mode the block models the three-level pull-up scheme:
- The very weak pull-up follows the latch.
- The weak pull-up also needs the sensed pin to read high.
- A short strong boost speeds up every 0-to-1 latch change.

Top module: `gpio_mode_ctrl`

## Requirements
- R1: Pin i (i < NUM_CFG) takes its mode from configuration bits [2i+1:2i]: 00 quasi-bidirectional, 01 input-only, 10 push-pull, 11 open-drain. An input-only pin asserts none of its four enables. The configuration register reads back as written.
- R2: In quasi-bidirectional mode the very weak pull-up is on exactly when the latch holds 1.
- R3: In quasi-bidirectional mode the weak pull-up is on only when the latch holds 1 and the filtered pin level is 1.
- R4: When a pin's latch changes from 0 to 1 in quasi-bidirectional mode, its strong pull-up is on for exactly the two cycles following the write edge, then off.
- R5: In push-pull mode the strong pull-up is on for as long as the latch holds 1, and the weak and very weak pull-ups stay off.
- R6: In open-drain mode all three pull-ups stay off.
- R7: In quasi-bidirectional, push-pull and open-drain modes the pull-down is on exactly when the latch holds 0.
- R8: A state register write leaves the latch of an input-only pin unchanged. After the pin is switched to a driving mode, its enables still reflect the old latch value.
- R9: The state read returns the filtered level of every pin. A new raw level is accepted only once it has been sampled on FILT_LEN consecutive clock edges, and it appears right after the last of those edges.
- R10: After reset the configuration register is 0x00, every latch is 1 (state latch 0x3F with the default six pins), and every filtered level is 1.
- R11: The two fixed pins (indices NUM_CFG and above) act as quasi-bidirectional whatever the configuration register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 2*NUM_CFG | Configuration write data, 2 bits per configurable pin |
| cfg_rdata_o | output | 2*NUM_CFG | Configuration register contents |
| state_we_i | input | 1 | State register write strobe |
| state_wdata_i | input | NUM_PIN | New latch values |
| state_rdata_o | output | NUM_PIN | Filtered pin levels |
| pin_i | input | NUM_PIN | Raw pin levels from the pads |
| strong_up_o | output | NUM_PIN | Strong pull-up enables |
| weak_up_o | output | NUM_PIN | Weak pull-up enables |
| vweak_up_o | output | NUM_PIN | Very weak pull-up enables |
| pull_dn_o | output | NUM_PIN | Pull-down enables |

## Verification
The bench targets these corner cases:
- A pin that returns high one edge short of the filter length. A filter that is off by one edge would pass that glitch through to the read value.
- The strong boost after a 0-to-1 write. A boost of the wrong length shows up on the first idle cycle after the second boost cycle.
- A state write to an input-only pin, followed by switching that pin to push-pull. A design that accepts the write would show a pull-down where a strong pull-up is expected.
- An all-ones configuration. A design that decodes missing configuration bits for the fixed pins would stop boosting them.

Random configuration and state writes, combined with slowly toggling pins, compare every enable against a reference model on every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    PM_QUASI = 2'b00,
    PM_INPUT = 2'b01,
    PM_PUSH  = 2'b10,
    PM_OPEN  = 2'b11
  } pin_mode_e;

  localparam int unsigned BOOST_CYC = 2;
endpackage

// File: rtl/gpio_glitch_filter.sv
module gpio_glitch_filter #(
  parameter int unsigned FILT_LEN = 3,
  parameter logic        RST_VAL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [CW-1:0] run_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      lvl_q <= RST_VAL;
    end else if (raw_i == lvl_q) begin
      run_q <= '0;
    end else if (run_q == CW'(FILT_LEN - 1)) begin
      lvl_q <= raw_i;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign filt_o = lvl_q;

  AST_FILT_FROM_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(raw_i))) else $error("filter"); // R9
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv
  import gpio_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pin_mode_e mode_i,
  input  logic      wr_i,
  input  logic      wdata_i,
  input  logic      sense_i,
  output logic      strong_o,
  output logic      weak_o,
  output logic      vweak_o,
  output logic      dn_o
);
  localparam int unsigned BW = $clog2(BOOST_CYC + 1);

  logic          lat_q, lat_d;
  logic [BW-1:0] boost_q;
  logic          boost_on;

  // input-only pins refuse writes
  always_comb lat_d = (wr_i && mode_i != PM_INPUT) ? wdata_i : lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q   <= 1'b1;
      boost_q <= '0;
    end else begin
      lat_q <= lat_d;
      if (!lat_d)            boost_q <= '0;
      else if (!lat_q)       boost_q <= BW'(BOOST_CYC);
      else if (boost_q != 0) boost_q <= boost_q - 1'b1;
    end
  end

  assign boost_on = (boost_q != '0);

  always_comb begin
    strong_o = 1'b0;
    weak_o   = 1'b0;
    vweak_o  = 1'b0;
    dn_o     = 1'b0;
    unique case (mode_i)
      PM_QUASI: begin
        strong_o = boost_on;
        weak_o   = lat_q & sense_i;
        vweak_o  = lat_q;
        dn_o     = ~lat_q;
      end
      PM_PUSH: begin
        strong_o = lat_q;
        dn_o     = ~lat_q;
      end
      PM_OPEN:  dn_o = ~lat_q;
      default: ;
    endcase
  end

  AST_INPUT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PM_INPUT) |-> !(strong_o || weak_o || vweak_o || dn_o)) else $error("in"); // R1
  AST_OPEN_NO_PULLUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PM_OPEN) |-> !(strong_o || weak_o || vweak_o)) else $error("od"); // R6
  AST_NO_FIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strong_o && dn_o)) else $error("fight"); // R7
  AST_BOOST_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boost_on && $past(boost_on)) |=> !boost_on) else $error("boost"); // R4
endmodule

// File: rtl/gpio_mode_ctrl.sv
module gpio_mode_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_CFG  = 4,
  parameter int unsigned NUM_FIX  = 2,
  parameter int unsigned FILT_LEN = 3,
  localparam int unsigned NUM_PIN = NUM_CFG + NUM_FIX,
  localparam int unsigned CFG_W   = 2 * NUM_CFG
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic [CFG_W-1:0]   cfg_rdata_o,
  input  logic               state_we_i,
  input  logic [NUM_PIN-1:0] state_wdata_i,
  output logic [NUM_PIN-1:0] state_rdata_o,
  input  logic [NUM_PIN-1:0] pin_i,
  output logic [NUM_PIN-1:0] strong_up_o,
  output logic [NUM_PIN-1:0] weak_up_o,
  output logic [NUM_PIN-1:0] vweak_up_o,
  output logic [NUM_PIN-1:0] pull_dn_o
);
  logic [CFG_W-1:0]   cfg_q;
  logic [NUM_PIN-1:0] lvl;
  pin_mode_e          pin_mode [NUM_PIN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_wdata_i;
  end

  assign cfg_rdata_o   = cfg_q;
  assign state_rdata_o = lvl;

  for (genvar i = 0; i < NUM_PIN; i++) begin : g_pin
    if (i < NUM_CFG) begin : g_cfg
      assign pin_mode[i] = pin_mode_e'(cfg_q[2*i +: 2]);
    end else begin : g_fix
      assign pin_mode[i] = PM_QUASI;
    end

    gpio_glitch_filter #(
      .FILT_LEN (FILT_LEN),
      .RST_VAL  (1'b1)
    ) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (pin_i[i]),
      .filt_o (lvl[i])
    );

    gpio_pin_drv u_drv (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (pin_mode[i]),
      .wr_i     (state_we_i),
      .wdata_i  (state_wdata_i[i]),
      .sense_i  (lvl[i]),
      .strong_o (strong_up_o[i]),
      .weak_o   (weak_up_o[i]),
      .vweak_o  (vweak_up_o[i]),
      .dn_o     (pull_dn_o[i])
    );

    AST_WEAK_NEEDS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      weak_up_o[i] |-> (state_rdata_o[i] && vweak_up_o[i])) else $error("weak"); // R3
    AST_VWEAK_NOT_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vweak_up_o[i] |-> !pull_dn_o[i]) else $error("vweak"); // R2
  end
endmodule

// File: tb/gpio_mode_ctrl_test.sv
`timescale 1ns/1ps
module gpio_mode_ctrl_test;
  localparam int NC = 4, NF = 2, NP = NC + NF, FL = 3;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0, state_we_i = 1'b0;
  logic [2*NC-1:0] cfg_wdata_i = '0, cfg_rdata_o;
  logic [NP-1:0] state_wdata_i = '0, state_rdata_o, pin_i = '1;
  logic [NP-1:0] strong_up_o, weak_up_o, vweak_up_o, pull_dn_o;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model
  logic [2*NC-1:0] m_cfg;
  logic [NP-1:0]   m_lat, m_filt;
  int              m_boost [NP];
  int              m_run   [NP];

  always #5 clk_i = ~clk_i;

  gpio_mode_ctrl #(.NUM_CFG(NC), .NUM_FIX(NF), .FILT_LEN(FL)) uut (.*);

  function automatic logic [1:0] mode_of(int i);
    return (i < NC) ? m_cfg[2*i +: 2] : 2'b00;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_cfg = '0; m_lat = '1; m_filt = '1;
    for (int i = 0; i < NP; i++) begin m_boost[i] = 0; m_run[i] = 0; end
  endfunction

  function automatic void model_edge();
    for (int i = 0; i < NP; i++) begin
      logic nl;
      nl = (state_we_i && mode_of(i) != 2'b01) ? state_wdata_i[i] : m_lat[i];
      if (!nl) m_boost[i] = 0;
      else if (!m_lat[i]) m_boost[i] = 2;
      else if (m_boost[i] > 0) m_boost[i]--;
      m_lat[i] = nl;
      if (pin_i[i] == m_filt[i]) m_run[i] = 0;
      else if (m_run[i] == FL - 1) begin m_filt[i] = pin_i[i]; m_run[i] = 0; end
      else m_run[i]++;
    end
    if (cfg_we_i) m_cfg = cfg_wdata_i;
  endfunction

  task automatic compare_all();
    chk(cfg_rdata_o == m_cfg, "R1 cfg readback", cfg_rdata_o, m_cfg);
    chk(state_rdata_o == m_filt, "R9 state read", state_rdata_o, m_filt);
    for (int i = 0; i < NP; i++) begin
      logic [1:0] md; logic es, ew, ev, ed;
      md = mode_of(i);
      es = (md == 2'b00) ? (m_boost[i] != 0) : (md == 2'b10) ? m_lat[i] : 1'b0;
      ew = (md == 2'b00) & m_lat[i] & m_filt[i];
      ev = (md == 2'b00) & m_lat[i];
      ed = (md != 2'b01) & ~m_lat[i];
      chk(strong_up_o[i] == es, "R4/R5 strong", strong_up_o[i], es);
      chk(weak_up_o[i] == ew, "R3 weak", weak_up_o[i], ew);
      chk(vweak_up_o[i] == ev, "R2 vweak", vweak_up_o[i], ev);
      chk(pull_dn_o[i] == ed, "R7 pull_dn", pull_dn_o[i], ed);
    end
  endtask

  task automatic step(bit cwe, logic [2*NC-1:0] cw, bit swe, logic [NP-1:0] sw, logic [NP-1:0] pins);
    cfg_we_i = cwe; cfg_wdata_i = cw; state_we_i = swe; state_wdata_i = sw; pin_i = pins;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare_all();
    cfg_we_i = 1'b0; state_we_i = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (2) @(negedge clk_i);
    // R10 reset state
    chk(cfg_rdata_o == 0, "R10 cfg reset", cfg_rdata_o, 0);
    chk(state_rdata_o == 6'h3F, "R10 level reset", state_rdata_o, 6'h3F);
    chk(vweak_up_o == 6'h3F, "R10 latch reset", vweak_up_o, 6'h3F);
    chk(pull_dn_o == 0 && strong_up_o == 0, "R10 no drive", pull_dn_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4 boost after 0->1
    step(0, 0, 1, 6'h3E, 6'h3F);
    chk(pull_dn_o[0] == 1, "R7 dn on latch 0", pull_dn_o[0], 1);
    step(0, 0, 1, 6'h3F, 6'h3F);
    chk(strong_up_o[0] == 1, "R4 boost cycle 1", strong_up_o[0], 1);
    step(0, 0, 0, 0, 6'h3F);
    chk(strong_up_o[0] == 1, "R4 boost cycle 2", strong_up_o[0], 1);
    step(0, 0, 0, 0, 6'h3F);
    chk(strong_up_o[0] == 0, "R4 boost ends", strong_up_o[0], 0);

    // R9 filter: two-edge glitch rejected, three-edge accepted; R3 weak follows
    step(0, 0, 0, 0, 6'h37);
    step(0, 0, 0, 0, 6'h37);
    step(0, 0, 0, 0, 6'h3F);
    chk(state_rdata_o[3] == 1, "R9 glitch rejected", state_rdata_o[3], 1);
    repeat (2) step(0, 0, 0, 0, 6'h37);
    chk(state_rdata_o[3] == 1, "R9 not yet", state_rdata_o[3], 1);
    step(0, 0, 0, 0, 6'h37);
    chk(state_rdata_o[3] == 0, "R9 accepted", state_rdata_o[3], 0);
    chk(weak_up_o[3] == 0 && vweak_up_o[3] == 1, "R3 weak off on low pin", weak_up_o[3], 0);
    repeat (3) step(0, 0, 0, 0, 6'h3F);

    // R8 input-only pin 1 refuses write; R5 push-pull afterwards
    step(1, 8'h04, 0, 0, 6'h3F);
    chk(vweak_up_o[1] == 0 && pull_dn_o[1] == 0, "R1 input-only quiet", vweak_up_o[1], 0);
    step(0, 0, 1, 6'h3D, 6'h3F);
    chk(pull_dn_o[1] == 0, "R8 input-only quiet after write", pull_dn_o[1], 0);
    step(1, 8'h08, 0, 0, 6'h3F);
    chk(strong_up_o[1] == 1 && pull_dn_o[1] == 0, "R8 latch kept", strong_up_o[1], 1);
    chk(weak_up_o[1] == 0 && vweak_up_o[1] == 0, "R5 no weak in push-pull", weak_up_o[1], 0);

    // R6 open-drain on pin 2
    step(1, 8'h30, 0, 0, 6'h3F);
    chk({strong_up_o[2], weak_up_o[2], vweak_up_o[2]} == 0, "R6 no pull-ups", strong_up_o[2], 0);
    step(0, 0, 1, 6'h3B, 6'h3F);
    chk(pull_dn_o[2] == 1, "R6 dn on 0", pull_dn_o[2], 1);

    // R11 fixed pins stay quasi with all-ones config
    step(1, 8'hFF, 1, 6'h0F, 6'h3F);
    chk(pull_dn_o[5:4] == 2'b11, "R11 fixed dn", pull_dn_o[5:4], 3);
    step(0, 0, 1, 6'h3F, 6'h3F);
    chk(strong_up_o[5:4] == 2'b11, "R11 fixed boost", strong_up_o[5:4], 3);
    chk(vweak_up_o[5:4] == 2'b11, "R11 fixed vweak", vweak_up_o[5:4], 3);

    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [NP-1:0] p;
      p = pin_i;
      for (int b = 0; b < NP; b++) if ($urandom_range(7) == 0) p[b] = ~p[b];
      step($urandom_range(15) == 0, 8'($urandom), $urandom_range(3) == 0, 6'($urandom), p);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule